// File: doc/BRIEF.md
# Eight-bit ALU with Condition Flags

This block is the arithmetic and logic datapath of a small byte-wide processor core, together with its four-bit condition code register. Each cycle the instruction sequencer may present an opcode, two operands, an incoming carry and a per-flag update mask. On the next clock edge the block registers the result and folds the newly computed flags into the condition code register. Only the flags selected by the mask are updated, and every other flag keeps its value.

The operations cover the following:
- Addition, with or without carry.
- Subtraction, with or without borrow, done as two's complement addition.
- Compare and bit test. These set flags only and do not produce a result.
- Complement, AND, OR and XOR.
- Left and right shifts of zero to seven places.
- A right rotate of zero to seven places.

The carry flag works as a borrow flag on subtract and compare. On shifts and rotates it takes the last bit moved out. Software can write the condition code register directly. A call or interrupt sequence can also restore a saved copy of the register through a separate port, and the current value on `flags_o` is the copy to save.

Top module: `alu8_flags`

## Requirements
- R1: Opcode 0 adds `a_i + b_i` and opcode 1 adds `a_i + b_i + carry_i`. The result is the low eight bits. C is set exactly when the sum exceeds 255.
- R2: Opcode 2 computes `a_i - b_i` and opcode 3 computes `a_i - b_i - carry_i`, both in two's complement. C is set to 1 when a borrow occurs, that is, when the unsigned minuend is smaller than the subtrahend plus the borrow-in.
- R3: V is set on opcodes 0 to 4 when the signed result of the add or subtract lies outside -128..127. Every other opcode clears V.
- R4: For every opcode, N is bit 7 of the computed value and Z is 1 only when all eight bits of that value are zero. The flag layout is `{N,C,V,Z}` on bits 3..0.
- R5: Opcode 4 (compare) produces the same flags as opcode 2. Opcode 5 (bit test) computes N and Z from `a_i & b_i` and clears C and V. Neither opcode raises `result_wr_o` or changes `result_o`.
- R6: Opcode 6 gives `~a_i`, opcode 7 gives `a_i & b_i`, opcode 8 gives `a_i | b_i` and opcode 9 gives `a_i ^ b_i`. Each of them clears C and V.
- R7: Opcode 10 shifts `a_i` left and opcode 11 shifts it right, by `b_i[2:0]` places with zero fill. C is the last bit shifted out, and is 0 when the amount is 0.
- R8: Opcode 12 rotates `a_i` right by `b_i[2:0]` places. C is the last bit carried around from bit 0 to bit 7, and is 0 when the amount is 0.
- R9: A flag whose bit in `flag_mask_i` is 0 keeps its previous value across an operation.
- R10: `ccr_wr_i` loads `ccr_wdata_i` into the flags. `ccr_rest_i` loads `ccr_rest_data_i`. The direct write takes priority over the restore, and the restore takes priority over an operation in the same cycle.
- R11: Reset clears the result, `result_wr_o` and the flags. Cycles with no valid operation, and opcodes 13 to 15, change neither the flags nor the result, and `result_wr_o` stays 0.
- R12: The result and the flags appear on the clock edge that samples the operation. `result_wr_o` is high for that one cycle when a result-producing opcode was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Opcode (0..12 valid) |
| a_i | input | 8 | First operand; shift/rotate source |
| b_i | input | 8 | Second operand; bits 2..0 give the shift/rotate amount |
| carry_i | input | 1 | Carry or borrow input for opcodes 1 and 3 |
| flag_mask_i | input | 4 | Per-flag update enable, `{N,C,V,Z}` |
| ccr_wr_i | input | 1 | Direct flag register write |
| ccr_wdata_i | input | 4 | Data for the direct write |
| ccr_rest_i | input | 1 | Restore saved flags |
| ccr_rest_data_i | input | 4 | Saved flag value to restore |
| result_o | output | 8 | Registered result of the last result-producing operation |
| result_wr_o | output | 1 | One-cycle strobe: `result_o` was just written |
| flags_o | output | 4 | Condition code register `{N,C,V,Z}` |

## Verification
The assertions check on every cycle the following:
- Masked-off flags hold their value.
- Idle cycles leave the flags and the result untouched.
- Direct writes and restores take effect with the stated priority.
- N and Z agree with the registered result.
- Compare and bit test never strobe a write.
- The borrow on plain subtract matches an unsigned less-than.

The arithmetic values themselves can only be shown by the bench's scenarios. These include the carry and overflow corners of add and subtract, every shift and rotate amount with its carry-out, the logic results, and the behaviour of unused opcodes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CMP = 4'd4,
    OP_BIT = 4'd5,
    OP_CPL = 4'd6,
    OP_AND = 4'd7,
    OP_OR  = 4'd8,
    OP_XOR = 4'd9,
    OP_SHL = 4'd10,
    OP_SHR = 4'd11,
    OP_ROR = 4'd12
  } alu_op_e;

  // Condition code layout: bit3 N, bit2 C, bit1 V, bit0 Z
  typedef struct packed {
    logic n;
    logic c;
    logic v;
    logic z;
  } ccr_t;

  typedef enum logic [1:0] {
    LG_CPL = 2'd0,
    LG_AND = 2'd1,
    LG_OR  = 2'd2,
    LG_XOR = 2'd3
  } logic_sel_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ROTR  = 2'd2
  } shift_sel_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             use_cin,
  input  logic             sub,
  output logic [WIDTH-1:0] res,
  output logic             carry,
  output logic             ovf
);
  logic [WIDTH-1:0] b_eff;
  logic             c0;
  logic [WIDTH:0]   sum;

  always_comb begin
    // subtraction: minuend plus inverted subtrahend plus (1 - borrow_in)
    b_eff = sub ? ~b : b;
    if (use_cin) c0 = sub ? ~cin : cin;
    else         c0 = sub;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c0};
    res   = sum[WIDTH-1:0];
    // carry flag reports borrow when subtracting
    carry = sub ? ~sum[WIDTH] : sum[WIDTH];
    ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (res[WIDTH-1] != a[WIDTH-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_sel_e       sel,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    case (sel)
      LG_CPL:  res = ~a;
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      default: res = a ^ b;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [AW-1:0]    amt,
  input  shift_sel_e       mode,
  output logic [WIDTH-1:0] res,
  output logic             carry
);
  logic [WIDTH-1:0] shl_r [WIDTH];
  logic [WIDTH-1:0] shr_r [WIDTH];
  logic [WIDTH-1:0] ror_r [WIDTH];
  logic [WIDTH-1:0] shl_c;
  logic [WIDTH-1:0] shr_c;

  // one candidate per shift amount; the amount selects among them
  for (genvar k = 0; k < WIDTH; k++) begin : g_amt
    if (k == 0) begin : g_zero
      assign shl_r[k] = a;
      assign shr_r[k] = a;
      assign ror_r[k] = a;
      assign shl_c[k] = 1'b0;
      assign shr_c[k] = 1'b0;
    end else begin : g_nz
      assign shl_r[k] = a << k;
      assign shr_r[k] = a >> k;
      assign ror_r[k] = {a[k-1:0], a[WIDTH-1:k]};
      assign shl_c[k] = a[WIDTH-k];
      assign shr_c[k] = a[k-1];
    end
  end

  always_comb begin
    case (mode)
      SH_LEFT: begin
        res   = shl_r[amt];
        carry = shl_c[amt];
      end
      SH_RIGHT: begin
        res   = shr_r[amt];
        carry = shr_c[amt];
      end
      default: begin
        // the last bit carried round is the one leaving bit 0 last
        res   = ror_r[amt];
        carry = shr_c[amt];
      end
    endcase
  end
endmodule

// File: rtl/alu8_ccr.sv
module alu8_ccr
  import alu8_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic upd_en,
  input  ccr_t upd_mask,
  input  ccr_t upd_val,
  input  logic wr_en,
  input  ccr_t wr_val,
  input  logic rs_en,
  input  ccr_t rs_val,
  output ccr_t flags_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (wr_en) begin
      flags_q <= wr_val;
    end else if (rs_en) begin
      flags_q <= rs_val;
    end else if (upd_en) begin
      flags_q <= (upd_val & upd_mask) | (flags_q & ~upd_mask);
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  input  logic [3:0]       flag_mask_i,
  input  logic             ccr_wr_i,
  input  logic [3:0]       ccr_wdata_i,
  input  logic             ccr_rest_i,
  input  logic [3:0]       ccr_rest_data_i,
  output logic [WIDTH-1:0] result_o,
  output logic             result_wr_o,
  output logic [3:0]       flags_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic             ar_sub, ar_cin_en, ar_c, ar_v;
  logic [WIDTH-1:0] ar_res, lg_res, sh_res;
  logic             sh_c;
  logic_sel_e       lg_sel;
  shift_sel_e       sh_sel;

  always_comb begin
    ar_sub    = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    ar_cin_en = (op == OP_ADC) || (op == OP_SBC);
    case (op)
      OP_CPL:         lg_sel = LG_CPL;
      OP_AND, OP_BIT: lg_sel = LG_AND;
      OP_OR:          lg_sel = LG_OR;
      default:        lg_sel = LG_XOR;
    endcase
    case (op)
      OP_SHL:  sh_sel = SH_LEFT;
      OP_SHR:  sh_sel = SH_RIGHT;
      default: sh_sel = SH_ROTR;
    endcase
  end

  alu8_arith #(.WIDTH(WIDTH)) i_arith (
    .a(a_i), .b(b_i), .cin(carry_i), .use_cin(ar_cin_en), .sub(ar_sub),
    .res(ar_res), .carry(ar_c), .ovf(ar_v)
  );

  alu8_logic #(.WIDTH(WIDTH)) i_logic (
    .a(a_i), .b(b_i), .sel(lg_sel), .res(lg_res)
  );

  alu8_shift #(.WIDTH(WIDTH)) i_shift (
    .a(a_i), .amt(b_i[AW-1:0]), .mode(sh_sel), .res(sh_res), .carry(sh_c)
  );

  logic [WIDTH-1:0] val_n;
  logic             c_n, v_n, known, writes;
  ccr_t             nf;

  always_comb begin
    val_n  = '0;
    c_n    = 1'b0;
    v_n    = 1'b0;
    known  = 1'b1;
    writes = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        val_n  = ar_res;
        c_n    = ar_c;
        v_n    = ar_v;
        writes = (op != OP_CMP);
      end
      OP_BIT, OP_CPL, OP_AND, OP_OR, OP_XOR: begin
        val_n  = lg_res;
        writes = (op != OP_BIT);
      end
      OP_SHL, OP_SHR, OP_ROR: begin
        val_n = sh_res;
        c_n   = sh_c;
      end
      default: begin
        known  = 1'b0;
        writes = 1'b0;
      end
    endcase
    nf.n = val_n[WIDTH-1];
    nf.c = c_n;
    nf.v = v_n;
    nf.z = (val_n == '0);
  end

  logic go;
  assign go = op_valid_i && known;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o    <= '0;
      result_wr_o <= 1'b0;
    end else begin
      result_wr_o <= go && writes;
      if (go && writes) result_o <= val_n;
    end
  end

  ccr_t flags_q;

  alu8_ccr i_ccr (
    .clk(clk), .rst(rst),
    .upd_en(go), .upd_mask(ccr_t'(flag_mask_i)), .upd_val(nf),
    .wr_en(ccr_wr_i), .wr_val(ccr_t'(ccr_wdata_i)),
    .rs_en(ccr_rest_i), .rs_val(ccr_t'(ccr_rest_data_i)),
    .flags_q(flags_q)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       flag_mask_i,
  input logic             ccr_wr_i,
  input logic [3:0]       ccr_wdata_i,
  input logic             ccr_rest_i,
  input logic [3:0]       ccr_rest_data_i,
  input logic [WIDTH-1:0] result_o,
  input logic             result_wr_o,
  input logic [3:0]       flags_o
);
  logic no_load, wr_op, flag_only_op;
  assign no_load      = !ccr_wr_i && !ccr_rest_i;
  assign flag_only_op = (op_i == OP_CMP) || (op_i == OP_BIT);
  assign wr_op        = (op_i <= OP_ROR) && !flag_only_op;

  // R9: masked-off flags keep their value
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && no_load |=>
      ((flags_o & ~$past(flag_mask_i)) == ($past(flags_o) & ~$past(flag_mask_i))));

  // R11: an idle cycle touches nothing
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !op_valid_i && no_load |=> $stable(flags_o) && $stable(result_o) && !result_wr_o);

  // R10: direct write wins
  p_ccr_write_r10: assert property (@(posedge clk) disable iff (rst)
    ccr_wr_i |=> flags_o == $past(ccr_wdata_i));

  // R10: restore when no direct write
  p_ccr_restore_r10: assert property (@(posedge clk) disable iff (rst)
    ccr_rest_i && !ccr_wr_i |=> flags_o == $past(ccr_rest_data_i));

  // R4: Z follows the written result
  p_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && wr_op && flag_mask_i[0] && no_load |=> flags_o[0] == (result_o == '0));

  // R4: N follows the written result
  p_neg_flag_r4: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && wr_op && flag_mask_i[3] && no_load |=> flags_o[3] == result_o[WIDTH-1]);

  // R5: compare and bit test never write a result
  p_flag_only_r5: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && flag_only_op |=> !result_wr_o && $stable(result_o));

  // R2: borrow on plain subtract equals unsigned less-than
  p_borrow_r2: assert property (@(posedge clk) disable iff (rst)
    op_valid_i && (op_i == OP_SUB) && flag_mask_i[2] && no_load |=>
      flags_o[2] == ($past(a_i) < $past(b_i)));

  // R12: write strobe only after an accepted result op
  p_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    result_wr_o |-> $past(op_valid_i) && ($past(op_i) <= OP_ROR));
endmodule

bind alu8_flags alu8_flags_chk #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .flag_mask_i(flag_mask_i),
  .ccr_wr_i(ccr_wr_i), .ccr_wdata_i(ccr_wdata_i),
  .ccr_rest_i(ccr_rest_i), .ccr_rest_data_i(ccr_rest_data_i),
  .result_o(result_o), .result_wr_o(result_wr_o), .flags_o(flags_o)
);

// File: tb/test_alu8_flags.sv
`timescale 1ns/1ps
module test_alu8_flags;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic       carry_i = 1'b0;
  logic [3:0] flag_mask_i = 4'hF;
  logic       ccr_wr_i = 1'b0, ccr_rest_i = 1'b0;
  logic [3:0] ccr_wdata_i = '0, ccr_rest_data_i = '0;
  logic [7:0] result_o;
  logic       result_wr_o;
  logic [3:0] flags_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_res = '0;
  logic [3:0] exp_flags = '0;

  always #5 clk = ~clk;

  alu8_flags i_alu8_flags (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .carry_i(carry_i), .flag_mask_i(flag_mask_i),
    .ccr_wr_i(ccr_wr_i), .ccr_wdata_i(ccr_wdata_i),
    .ccr_rest_i(ccr_rest_i), .ccr_rest_data_i(ccr_rest_data_i),
    .result_o(result_o), .result_wr_o(result_wr_o), .flags_o(flags_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic void model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                                input logic ci, output logic [7:0] r, output logic [3:0] f,
                                output logic wr, output logic known);
    int s, ss, n;
    logic c, v;
    c = 0; v = 0; wr = 1; known = 1; r = 0;
    n = int'(b[2:0]);
    case (op)
      0, 1: begin
        s  = int'(a) + int'(b) + ((op == 1) ? int'(ci) : 0);
        ss = int'($signed(a)) + int'($signed(b)) + ((op == 1) ? int'(ci) : 0);
        r = s[7:0]; c = (s > 255); v = (ss > 127) || (ss < -128);
      end
      2, 3, 4: begin
        s  = int'(a) - int'(b) - ((op == 3) ? int'(ci) : 0);
        ss = int'($signed(a)) - int'($signed(b)) - ((op == 3) ? int'(ci) : 0);
        r = s[7:0]; c = (s < 0); v = (ss > 127) || (ss < -128);
        wr = (op != 4);
      end
      5: begin r = a & b; wr = 0; end
      6: r = ~a;
      7: r = a & b;
      8: r = a | b;
      9: r = a ^ b;
      10: begin r = a << n; c = (n == 0) ? 1'b0 : a[8-n]; end
      11: begin r = a >> n; c = (n == 0) ? 1'b0 : a[n-1]; end
      12: begin r = (a >> n) | (a << (8 - n)); c = (n == 0) ? 1'b0 : a[n-1]; end
      default: begin known = 0; wr = 0; end
    endcase
    f = {r[7], c, v, (r == 8'h00)};
  endfunction

  // Drive one operation at a falling edge, check after the capturing edge
  task automatic run_op(input string req, input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic ci, input logic [3:0] mask);
    logic [7:0] r; logic [3:0] f; logic wr, known;
    model(op, a, b, ci, r, f, wr, known);
    op_i = op; a_i = a; b_i = b; carry_i = ci; flag_mask_i = mask; op_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid_i = 1'b0;
    if (known) exp_flags = (f & mask) | (exp_flags & ~mask);
    if (wr) exp_res = r;
    check(req, $sformatf("op%0d a=%02h b=%02h result", op, a, b), int'(result_o), int'(exp_res));
    check(req, $sformatf("op%0d a=%02h b=%02h strobe", op, a, b), int'(result_wr_o), int'(wr));
    check(req, $sformatf("op%0d a=%02h b=%02h flags", op, a, b), int'(flags_o), int'(exp_flags));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_res = '0; exp_flags = '0;
    check("R11", "reset result", int'(result_o), 0);
    check("R11", "reset strobe", int'(result_wr_o), 0);
    check("R11", "reset flags", int'(flags_o), 0);
  endtask

  task automatic t_add();
    run_op("R1", 4'd0, 8'h8C, 8'hEA, 1'b0, 4'hF);   // carry and signed overflow
    check("R3", "V on neg+neg overflow", int'(flags_o[1]), 1);
    run_op("R3", 4'd0, 8'h7F, 8'h01, 1'b0, 4'hF);   // positive overflow
    run_op("R4", 4'd0, 8'h00, 8'h00, 1'b0, 4'hF);   // zero
    run_op("R1", 4'd0, 8'hFF, 8'h01, 1'b1, 4'hF);   // carry_i ignored by plain add
    run_op("R1", 4'd1, 8'hFF, 8'h00, 1'b1, 4'hF);   // adc carries through
    run_op("R1", 4'd1, 8'h12, 8'h34, 1'b1, 4'hF);
  endtask

  task automatic t_sub();
    run_op("R2", 4'd2, 8'h10, 8'h20, 1'b0, 4'hF);   // borrow
    run_op("R2", 4'd2, 8'h20, 8'h20, 1'b0, 4'hF);   // equal, zero, no borrow
    run_op("R3", 4'd2, 8'h80, 8'h01, 1'b0, 4'hF);   // signed overflow
    run_op("R2", 4'd3, 8'h00, 8'h00, 1'b1, 4'hF);   // sbc borrow-in
    run_op("R2", 4'd3, 8'h50, 8'h10, 1'b0, 4'hF);
  endtask

  task automatic t_flag_only();
    run_op("R1", 4'd0, 8'h33, 8'h44, 1'b0, 4'hF);   // known result first
    run_op("R5", 4'd4, 8'h05, 8'h06, 1'b0, 4'hF);   // compare: borrow, no write
    run_op("R5", 4'd4, 8'h7F, 8'h80, 1'b0, 4'hF);   // compare overflow
    run_op("R5", 4'd5, 8'hF0, 8'h0F, 1'b0, 4'hF);   // bit test zero
    run_op("R5", 4'd5, 8'h80, 8'hC0, 1'b0, 4'hF);   // bit test negative
  endtask

  task automatic t_logic();
    run_op("R6", 4'd2, 8'h00, 8'h01, 1'b0, 4'hF);   // set C before logic op
    run_op("R6", 4'd6, 8'h5A, 8'h00, 1'b0, 4'hF);
    run_op("R6", 4'd7, 8'hCC, 8'hAA, 1'b0, 4'hF);
    run_op("R6", 4'd8, 8'h0C, 8'h30, 1'b0, 4'hF);
    run_op("R6", 4'd9, 8'hA5, 8'hA5, 1'b0, 4'hF);
  endtask

  task automatic t_shift_rot();
    for (int k = 0; k < 8; k++) run_op("R7", 4'd10, 8'hB5, 8'(k), 1'b0, 4'hF);
    for (int k = 0; k < 8; k++) run_op("R7", 4'd11, 8'hAD, 8'(k), 1'b0, 4'hF);
    for (int k = 0; k < 8; k++) run_op("R8", 4'd12, 8'h96, 8'(k), 1'b0, 4'hF);
    run_op("R8", 4'd12, 8'h01, 8'h01, 1'b0, 4'hF);  // bit 0 wraps to bit 7, C=1
    check("R8", "rotate 01 by 1 carry", int'(flags_o[2]), 1);
  endtask

  task automatic t_mask();
    run_op("R9", 4'd0, 8'h8C, 8'hEA, 1'b0, 4'hF);   // N0 C1 V1 Z0
    run_op("R9", 4'd0, 8'h00, 8'h00, 1'b0, 4'b0001); // only Z updates
    run_op("R9", 4'd2, 8'h80, 8'h00, 1'b0, 4'b1000); // only N updates
    run_op("R9", 4'd9, 8'h11, 8'h22, 1'b0, 4'b0000); // nothing updates
  endtask

  task automatic t_ccr();
    ccr_wr_i = 1'b1; ccr_wdata_i = 4'b1010;
    @(posedge clk); @(negedge clk);
    ccr_wr_i = 1'b0; exp_flags = 4'b1010;
    check("R10", "direct write", int'(flags_o), int'(exp_flags));
    ccr_rest_i = 1'b1; ccr_rest_data_i = 4'b0101;
    @(posedge clk); @(negedge clk);
    ccr_rest_i = 1'b0; exp_flags = 4'b0101;
    check("R10", "restore", int'(flags_o), int'(exp_flags));
    ccr_wr_i = 1'b1; ccr_wdata_i = 4'b1100; ccr_rest_i = 1'b1; ccr_rest_data_i = 4'b0011;
    @(posedge clk); @(negedge clk);
    ccr_wr_i = 1'b0; ccr_rest_i = 1'b0; exp_flags = 4'b1100;
    check("R10", "write beats restore", int'(flags_o), int'(exp_flags));
    // restore beats an operation; the result still gets written
    ccr_rest_i = 1'b1; ccr_rest_data_i = 4'b0110;
    op_i = 4'd0; a_i = 8'h01; b_i = 8'h01; flag_mask_i = 4'hF; op_valid_i = 1'b1;
    @(posedge clk); @(negedge clk);
    ccr_rest_i = 1'b0; op_valid_i = 1'b0; exp_flags = 4'b0110; exp_res = 8'h02;
    check("R10", "restore beats op flags", int'(flags_o), int'(exp_flags));
    check("R12", "result beside restore", int'(result_o), int'(exp_res));
  endtask

  task automatic t_idle();
    run_op("R11", 4'd0, 8'h70, 8'h10, 1'b0, 4'hF);
    @(posedge clk); @(negedge clk);
    check("R12", "strobe drops after one cycle", int'(result_wr_o), 0);
    check("R11", "idle result", int'(result_o), int'(exp_res));
    run_op("R11", 4'd13, 8'h00, 8'h00, 1'b0, 4'hF);
    run_op("R11", 4'd15, 8'hFF, 8'h01, 1'b0, 4'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_flag_only();
    t_logic();
    t_shift_rot();
    t_mask();
    t_ccr();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule